// File: doc/BRIEF.md
# Round-Robin Transmit Line Scanner

This block picks which line of an eight-line asynchronous serial multiplexer gets the next transmit character. Each line has an enable bit, taken from the low byte of the transmit control register, and a transmitter-empty status bit. A line qualifies when both bits are set. When a scan runs, the block searches the lines in a circle. The search starts at the line just after the one it last reported and wraps past the top line back to line 0. The first qualifying line it finds becomes the reported line, and the transmit-ready flag is raised. If no line qualifies, the ready flag is dropped and the reported line is left as it was.

A scan runs on three events: a transmit-control write, a low-byte transmit-data write and a periodic poll tick. It runs only while master scan enable is on. A low-byte data write with the scanner on sends the character to the line reported at that moment. Only the low seven bits of the character are sent. The same write then rescans from that line. A high-byte data write only stores the byte. A transmit interrupt request follows the ready flag, gated by the interrupt enable.

Top module: `txscan_top`

## Requirements
- R1: After reset, tx_ready, tx_irq and send_valid are 0, tx_line is 0 and data_word is 0.
- R2: A scan that runs in a cycle examines lines in the order tx_line+1, tx_line+2, and so on, modulo NUM_LINES, ending with tx_line itself. After the clock edge, tx_line holds the first qualifying line found and tx_ready is 1.
- R3: A line qualifies only when both its line_enable bit and its line_empty bit are 1. If a scan finds no qualifying line, tx_ready becomes 0 and tx_line keeps its value.
- R4: tx_irq in any cycle equals tx_int_en sampled at the preceding clock edge ANDed with tx_ready in that cycle.
- R5: While scan_en is 0 at a clock edge, tx_ready is 0 after that edge, no scan runs and tx_line holds.
- R6: A data_wr_lo pulse with scan_en 1 produces a one-cycle send_valid after the edge. send_line is tx_line as it was before the edge, and send_char is data_in[6:0]. A rescan then runs in the same edge.
- R7: A data_wr_lo pulse with scan_en 0 stores data_in into data_word[7:0] and produces no send_valid.
- R8: A data_wr_hi pulse stores data_in into data_word[15:8]. Alone, it produces no send_valid and no rescan: tx_ready and tx_line hold.
- R9: With scan_en 1, a scan runs only in a cycle with ctl_wr, data_wr_lo or poll_tick. In other cycles tx_ready and tx_line hold, even if line_enable or line_empty change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | Master scan enable |
| tx_int_en | input | 1 | Transmit interrupt enable |
| line_enable | input | NUM_LINES | Per-line transmit enable (control register low byte) |
| line_empty | input | NUM_LINES | Per-line transmitter-empty status |
| ctl_wr | input | 1 | Transmit control register write strobe |
| poll_tick | input | 1 | Periodic poll strobe |
| data_wr_lo | input | 1 | Transmit data low-byte write strobe |
| data_wr_hi | input | 1 | Transmit data high-byte write strobe |
| data_in | input | 8 | Write data byte |
| tx_ready | output | 1 | A qualifying line was found by the last scan |
| tx_line | output | LINE_W | Reported transmit line number |
| tx_irq | output | 1 | Transmit interrupt request |
| send_valid | output | 1 | One-cycle character send strobe |
| send_line | output | LINE_W | Line receiving the character |
| send_char | output | 7 | Character sent, low seven bits |
| data_word | output | 16 | Stored transmit data word |

## Verification
Some properties are checked by assertions on every cycle:
- the interrupt tracks the interrupt enable and the ready flag;
- ready is low whenever master scan enable was off;
- line and ready hold in cycles with no trigger;
- a line reported after a scan did qualify in that cycle;
- every send strobe comes from an enabled low-byte write and uses the previously reported line.

Other properties only the bench's scenarios can show, because they need the reference scan model:
- the circular order and the wrap from the top line to line 0;
- picking the first qualifying line and not just some qualifying line;
- the no-hit case that keeps the old line;
- the byte-lane contents of the stored data word.

// File: rtl/txscan_pkg.sv
package txscan_pkg;

    // What the scanner does with its ready/line state in a given cycle.
    typedef enum logic [1:0] {
        SCAN_HOLD = 2'd0,   // no trigger: keep ready and line
        SCAN_RUN  = 2'd1,   // trigger with scanner on: search lines
        SCAN_OFF  = 2'd2    // scanner off: force ready low
    } scan_act_e;

    localparam int BYTE_W = 8;
    localparam int CHAR_W = 7;
    localparam int WORD_W = 2 * BYTE_W;

endpackage

// File: rtl/txscan_pick.sv
// Circular line search: rotate qualify vector so the line after the start
// sits at bit 0, then take the lowest set bit.
module txscan_pick #(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [LINE_W-1:0]    start_line,
    input  logic [NUM_LINES-1:0] qual,
    output logic                 hit,
    output logic [LINE_W-1:0]    pick_line
);
    localparam int SUM_W = LINE_W + 2;

    logic [NUM_LINES-1:0] rot;
    logic [SUM_W-1:0]     off;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_rot
        logic [SUM_W-1:0] raw;
        logic [SUM_W-1:0] idx;
        always_comb begin
            raw = SUM_W'(start_line) + SUM_W'(g + 1);
            idx = (raw >= SUM_W'(NUM_LINES)) ? raw - SUM_W'(NUM_LINES) : raw;
        end
        assign rot[g] = qual[idx[LINE_W-1:0]];
    end

    always_comb begin
        hit = 1'b0;
        off = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (rot[i]) begin
                hit = 1'b1;
                off = SUM_W'(i);
            end
        end
    end

    logic [SUM_W-1:0] pick_raw;
    always_comb begin
        pick_raw  = SUM_W'(start_line) + off + SUM_W'(1);
        if (pick_raw >= SUM_W'(NUM_LINES)) begin
            pick_raw = pick_raw - SUM_W'(NUM_LINES);
        end
        pick_line = pick_raw[LINE_W-1:0];
    end

endmodule

// File: rtl/txscan_ctrl.sv
// Decides per cycle whether the scanner holds, scans or is forced off.
module txscan_ctrl
    import txscan_pkg::*;
(
    input  logic      scan_en,
    input  logic      ctl_wr,
    input  logic      poll_tick,
    input  logic      data_wr_lo,
    output scan_act_e act
);
    always_comb begin
        if (!scan_en) begin
            act = SCAN_OFF;
        end else if (ctl_wr || poll_tick || data_wr_lo) begin
            act = SCAN_RUN;
        end else begin
            act = SCAN_HOLD;
        end
    end
endmodule

// File: rtl/txscan_data.sv
// Transmit data word and character send strobe.
module txscan_data
    import txscan_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              data_wr_lo,
    input  logic              data_wr_hi,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [LINE_W-1:0] cur_line,
    output logic              send_valid,
    output logic [LINE_W-1:0] send_line,
    output logic [CHAR_W-1:0] send_char,
    output logic [WORD_W-1:0] data_word
);
    typedef struct packed {
        logic              send;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] chr;
        logic [WORD_W-1:0] word;
    } dstate_t;

    dstate_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.send = 1'b0;
        if (data_wr_hi) begin
            st_d.word[WORD_W-1:BYTE_W] = data_in;
        end
        if (data_wr_lo) begin
            st_d.word[BYTE_W-1:0] = data_in;
            if (scan_en) begin
                st_d.send = 1'b1;
                st_d.line = cur_line;
                st_d.chr  = data_in[CHAR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign send_valid = st_q.send;
    assign send_line  = st_q.line;
    assign send_char  = st_q.chr;
    assign data_word  = st_q.word;
endmodule

// File: rtl/txscan_top.sv
module txscan_top
    import txscan_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_en,
    input  logic                 tx_int_en,
    input  logic [NUM_LINES-1:0] line_enable,
    input  logic [NUM_LINES-1:0] line_empty,
    input  logic                 ctl_wr,
    input  logic                 poll_tick,
    input  logic                 data_wr_lo,
    input  logic                 data_wr_hi,
    input  logic [BYTE_W-1:0]    data_in,
    output logic                 tx_ready,
    output logic [LINE_W-1:0]    tx_line,
    output logic                 tx_irq,
    output logic                 send_valid,
    output logic [LINE_W-1:0]    send_line,
    output logic [CHAR_W-1:0]    send_char,
    output logic [WORD_W-1:0]    data_word
);
    typedef struct packed {
        logic              ready;
        logic [LINE_W-1:0] line;
        logic              irq;
    } sstate_t;

    sstate_t   st_d, st_q;
    scan_act_e act;
    logic      hit;
    logic [LINE_W-1:0]    pick_line;
    logic [NUM_LINES-1:0] qual;

    assign qual = line_enable & line_empty;

    txscan_ctrl u_ctrl (
        .scan_en    (scan_en),
        .ctl_wr     (ctl_wr),
        .poll_tick  (poll_tick),
        .data_wr_lo (data_wr_lo),
        .act        (act)
    );

    txscan_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_pick (
        .start_line (st_q.line),
        .qual       (qual),
        .hit        (hit),
        .pick_line  (pick_line)
    );

    txscan_data #(.LINE_W(LINE_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .data_wr_lo (data_wr_lo),
        .data_wr_hi (data_wr_hi),
        .data_in    (data_in),
        .cur_line   (st_q.line),
        .send_valid (send_valid),
        .send_line  (send_line),
        .send_char  (send_char),
        .data_word  (data_word)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            SCAN_OFF: st_d.ready = 1'b0;
            SCAN_RUN: begin
                st_d.ready = hit;
                if (hit) begin
                    st_d.line = pick_line;
                end
            end
            default: ;
        endcase
        st_d.irq = tx_int_en && st_d.ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ready = st_q.ready;
    assign tx_line  = st_q.line;
    assign tx_irq   = st_q.irq;
endmodule

// File: rtl/txscan_chk.sv
module txscan_chk #(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scan_en,
    input logic                 tx_int_en,
    input logic [NUM_LINES-1:0] line_enable,
    input logic [NUM_LINES-1:0] line_empty,
    input logic                 ctl_wr,
    input logic                 poll_tick,
    input logic                 data_wr_lo,
    input logic                 data_wr_hi,
    input logic                 tx_ready,
    input logic [LINE_W-1:0]    tx_line,
    input logic                 tx_irq,
    input logic                 send_valid,
    input logic [LINE_W-1:0]    send_line
);
    logic [NUM_LINES-1:0] qual_prev;
    logic                 scan_prev;
    logic                 live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_prev <= '0;
            scan_prev <= 1'b0;
            live      <= 1'b0;
        end else begin
            qual_prev <= line_enable & line_empty;
            scan_prev <= scan_en && (ctl_wr || poll_tick || data_wr_lo);
            live      <= 1'b1;
        end
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (tx_irq == ($past(tx_int_en) && tx_ready))); // R4

    AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(scan_en)) |-> !tx_ready); // R5

    AST_HOLD_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(scan_en) && !$past(ctl_wr || poll_tick || data_wr_lo))
        |-> ($stable(tx_ready) && $stable(tx_line))); // R9

    AST_PICK_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        (live && scan_prev && tx_ready) |-> qual_prev[tx_line]); // R3

    AST_SEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && send_valid) |-> ($past(scan_en && data_wr_lo)
                                  && send_line == $past(tx_line))); // R6

    AST_HI_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_hi && !data_wr_lo) |=> !send_valid); // R8

endmodule

bind txscan_top txscan_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .tx_int_en   (tx_int_en),
    .line_enable (line_enable),
    .line_empty  (line_empty),
    .ctl_wr      (ctl_wr),
    .poll_tick   (poll_tick),
    .data_wr_lo  (data_wr_lo),
    .data_wr_hi  (data_wr_hi),
    .tx_ready    (tx_ready),
    .tx_line     (tx_line),
    .tx_irq      (tx_irq),
    .send_valid  (send_valid),
    .send_line   (send_line)
);

// File: tb/txscan_top_tb.sv
module txscan_top_tb;
    localparam int N  = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0, tx_int_en = 1'b0;
    logic [N-1:0]  line_enable = '0, line_empty = '0;
    logic          ctl_wr = 1'b0, poll_tick = 1'b0;
    logic          data_wr_lo = 1'b0, data_wr_hi = 1'b0;
    logic [7:0]    data_in = '0;
    logic          tx_ready, tx_irq, send_valid;
    logic [LW-1:0] tx_line, send_line;
    logic [6:0]    send_char;
    logic [15:0]   data_word;

    int checks = 0;
    int failures = 0;

    // model state
    logic          m_ready = 1'b0, m_irq = 1'b0, m_send = 1'b0;
    logic [LW-1:0] m_line = '0, m_sline = '0;
    logic [6:0]    m_schar = '0;
    logic [15:0]   m_word = '0;

    always #2 clk = ~clk;

    txscan_top #(.NUM_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .tx_int_en(tx_int_en),
        .line_enable(line_enable), .line_empty(line_empty),
        .ctl_wr(ctl_wr), .poll_tick(poll_tick),
        .data_wr_lo(data_wr_lo), .data_wr_hi(data_wr_hi), .data_in(data_in),
        .tx_ready(tx_ready), .tx_line(tx_line), .tx_irq(tx_irq),
        .send_valid(send_valid), .send_line(send_line), .send_char(send_char),
        .data_word(data_word)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference circular search: returns -1 when nothing qualifies.
    function automatic int ref_scan(input int from, input logic [N-1:0] q);
        for (int k = 1; k <= N; k++) begin
            int l;
            l = (from + k) % N;
            if (q[l]) return l;
        end
        return -1;
    endfunction

    task automatic model_edge();
        logic trig;
        int   f;
        trig   = ctl_wr || poll_tick || data_wr_lo;
        m_send = scan_en && data_wr_lo;
        if (m_send) begin
            m_sline = m_line;
            m_schar = data_in[6:0];
        end
        if (data_wr_hi) m_word[15:8] = data_in;
        if (data_wr_lo) m_word[7:0]  = data_in;
        if (!scan_en) begin
            m_ready = 1'b0;
        end else if (trig) begin
            f = ref_scan(int'(m_line), line_enable & line_empty);
            m_ready = (f >= 0);
            if (f >= 0) m_line = LW'(f);
        end
        m_irq = tx_int_en && m_ready;
    endtask

    // inputs are already driven (after a negedge); apply one edge and check
    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
        check("R2/R3 ready", int'(tx_ready), int'(m_ready));
        check("R2 line", int'(tx_line), int'(m_line));
        check("R4 irq", int'(tx_irq), int'(m_irq));
        check("R6 send_valid", int'(send_valid), int'(m_send));
        if (m_send) begin
            check("R6 send_line", int'(send_line), int'(m_sline));
            check("R6 send_char", int'(send_char), int'(m_schar));
        end
        check("R7/R8 data_word", int'(data_word), int'(m_word));
        @(negedge clk);
        ctl_wr = 1'b0; poll_tick = 1'b0; data_wr_lo = 1'b0; data_wr_hi = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 ready", int'(tx_ready), 0);
        check("R1 line", int'(tx_line), 0);
        check("R1 irq", int'(tx_irq), 0);
        check("R1 send", int'(send_valid), 0);
        check("R1 word", int'(data_word), 0);
        @(negedge clk);

        // R2: first scan from line 0 examines line 1 before line 0
        scan_en = 1; tx_int_en = 1;
        line_enable = 8'h03; line_empty = 8'hFF; poll_tick = 1; step();
        check("R2 first scan picks line 1", int'(tx_line), 1);
        // R2: from line 1, lines 0 and 1 qualify -> wraps to 0
        poll_tick = 1; step();
        check("R2 wrap to 0", int'(tx_line), 0);
        // R2: from 0, 5 qualifies before 7
        line_enable = 8'hA0; ctl_wr = 1; step();
        check("R2 nearest 5", int'(tx_line), 5);
        poll_tick = 1; step();
        check("R2 next 7", int'(tx_line), 7);
        // R2 wrap from top line
        line_enable = 8'h01; poll_tick = 1; step();
        check("R2 wrap 7->0", int'(tx_line), 0);
        // R3: enabled but not empty is skipped
        line_enable = 8'h0C; line_empty = 8'h08; poll_tick = 1; step();
        check("R3 skip busy", int'(tx_line), 3);
        // R3: none qualifies -> ready 0, line held
        line_empty = 8'h00; poll_tick = 1; step();
        check("R3 no hit ready", int'(tx_ready), 0);
        check("R3 no hit line", int'(tx_line), 3);
        // R9: no trigger holds despite input change
        line_empty = 8'hFF; step();
        check("R9 hold ready", int'(tx_ready), 0);
        poll_tick = 1; step();
        check("R9 scan on poll", int'(tx_line), 2);
        // R6: send to reported line, masked char, then rescan
        data_in = 8'hC1; data_wr_lo = 1; step();
        check("R6 send line", int'(send_line), 2);
        check("R6 char masked", int'(send_char), 8'h41);
        // R8: high byte write only stores
        data_in = 8'h5A; data_wr_hi = 1; line_enable = 8'hFF; step();
        check("R8 no send", int'(send_valid), 0);
        check("R8 line held", int'(tx_line), 3);
        check("R8 hi byte", int'(data_word[15:8]), 8'h5A);
        // R5: scanner off forces ready low
        scan_en = 0; step();
        check("R5 ready off", int'(tx_ready), 0);
        check("R4 irq off", int'(tx_irq), 0);
        // R7: low write with scanner off stores, no send
        data_in = 8'h37; data_wr_lo = 1; step();
        check("R7 no send", int'(send_valid), 0);
        check("R7 lo byte", int'(data_word[7:0]), 8'h37);
        check("R5 line held", int'(tx_line), 3);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            scan_en     = ($urandom % 8) != 0;
            tx_int_en   = ($urandom % 4) != 0;
            line_enable = 8'($urandom);
            line_empty  = 8'($urandom) | 8'($urandom);
            ctl_wr      = ($urandom % 4) == 0;
            poll_tick   = ($urandom % 4) == 0;
            data_wr_lo  = ($urandom % 4) == 0;
            data_wr_hi  = ($urandom % 6) == 0;
            data_in     = 8'($urandom);
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule